// File: doc/BRIEF.md
# Local Bus Tenure Controller for a DMA Engine

This block decides when a DMA engine may occupy a shared local bus. It raises a hold request toward an external local arbiter and waits for the arbiter's acknowledge. It moves one longword per owned cycle while the FIFO allows it. It then gives the bus back for one of several reasons: the FIFO cannot continue, the tenure timer runs out, another master asks for the bus, or a direct-slave access is waiting. After that it backs off for a programmed pause and asks again. The engine only owns the bus while hold and acknowledge are both high, and only then are its bus outputs enabled.

A job starts with a one-cycle start pulse that carries a direction and a longword count. The block counts down one longword per transfer strobe. When the count runs out, it drops hold, pulses done and returns to idle. An enabled end-of-transfer input cuts a job short after the current local cycle. The data path, the FIFOs and the host-bus side sit outside this block.

Top module: `dma_lbus_owner`

## Requirements
- R1: After reset, hold_o, drive_en_o, xfer_o and done_o are all low and the block is idle.
- R2: A start pulse in idle raises hold_o after the next edge. Once hold_ack_i is sampled high with hold_o high, drive_en_o rises after the following edge. drive_en_o is high only while hold_o and hold_ack_i are both high.
- R3: In every cycle where drive_en_o is high and the FIFO does not block, xfer_o is high. With dir_i=1 (local-to-host) fifo_full_i blocks; with dir_i=0 (host-to-local) fifo_empty_i blocks. A blocked owned cycle gives no strobe and hold_o falls after that edge. The flag of the other direction has no effect.
- R4: Each strobe consumes one longword. The edge after the strobe that consumes the last longword drops hold_o and raises done_o for exactly one cycle. A start with count 0 pulses done_o without raising hold_o.
- R5: With a nonzero latency value L, the latency counter reloads on each acquisition, and a tenure lasts at most L owned cycles. The longword in the last cycle completes, then hold_o falls. L=0 turns the latency timer off.
- R6: After a release, hold_o stays low for at least P+1 cycles, where P is the pause value. It rises again only once the pause count is zero and hold_ack_i is sampled low. The job then resumes with its remaining count.
- R7: ext_mode_i selects how the other master's request is handled: 0 ignores ext_req_i, 1 releases the bus with at most two strobes after the request is seen, and 2 releases only when the latency timer has also expired (so with L=0 it is ignored). Value 3 acts like 0.
- R8: slave_pend_i high during an owned cycle releases the bus after that cycle.
- R9: With eot_en_i high, eot_i high in an owned cycle makes that cycle the last one of the job: done_o pulses after it, whatever count remains. With eot_en_i low, eot_i has no effect.
- R10: If a release reason coincides with the final longword, the job completes. done_o pulses, and hold_o stays low in idle with no pause and no new request.
- R11: A start pulse while a job is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle job start, taken only in idle |
| dir_i | input | 1 | 1 = local-to-host, 0 = host-to-local; captured at start |
| count_i | input | CNT_W | Longwords in the job; captured at start |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| ext_req_i | input | 1 | Bus request from another local master |
| ext_mode_i | input | 2 | 0 ignore, 1 release, 2 release when latency expired |
| slave_pend_i | input | 1 | Direct-slave access waiting |
| eot_i | input | 1 | End-of-transfer request |
| eot_en_i | input | 1 | Enables eot_i |
| lat_val_i | input | TMR_W | Latency limit in owned cycles, 0 = off |
| pause_val_i | input | TMR_W | Back-off length after a release |
| hold_ack_i | input | 1 | Acknowledge from the local arbiter |
| hold_o | output | 1 | Hold request to the local arbiter |
| drive_en_o | output | 1 | Enables the local bus drivers |
| xfer_o | output | 1 | One longword moves in this cycle |
| done_o | output | 1 | One-cycle job completion pulse |

## Verification
The assertions take for granted that the arbiter drops hold_ack_i no later than the cycle in which hold_o falls. They also assume that lat_val_i, pause_val_i and the direction-relevant flags stay steady while the checker compares them against a tenure. The bench models the arbiter as hold_o gated by a grant enable, ORed with a "bus used by another master" flag that it raises only during a pause. It changes timer values and modes only between jobs. End-of-transfer and slave pulses are issued only in owned cycles, so every rule is exercised where it applies.

// File: rtl/dma_lbus_pkg.sv
package dma_lbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_OWN   = 2'd2,
    ST_PAUSE = 2'd3
  } own_st_e;

  typedef enum logic [1:0] {
    XREQ_OFF   = 2'd0,
    XREQ_ON    = 2'd1,
    XREQ_GATED = 2'd2,
    XREQ_RSVD  = 2'd3
  } xreq_mode_e;

endpackage

// File: rtl/dma_lbus_tmr.sv
// Loadable down counter that stops at zero; used for tenure and back-off.
module dma_lbus_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= ZERO;
    end else if (load_i) begin
      cnt_o <= val_i;
    end else if (run_i && cnt_o != ZERO) begin
      cnt_o <= cnt_o - ONE;
    end
  end

endmodule

// File: rtl/dma_lbus_rel.sv
// Collects the reasons, other than FIFO state, to give the bus back.
module dma_lbus_rel
  import dma_lbus_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_req_i,
  input  logic [1:0]       ext_mode_i,
  input  logic             slave_pend_i,
  input  logic [TMR_W-1:0] lat_val_i,
  input  logic [TMR_W-1:0] lat_cnt_i,
  output logic             lat_exp_o,
  output logic             rel_o
);

  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic       ext_q;
  logic       ext_hit;
  xreq_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_req_i;
  end

  assign mode      = xreq_mode_e'(ext_mode_i);
  assign lat_exp_o = (lat_val_i != '0) && (lat_cnt_i <= ONE);

  always_comb begin
    unique case (mode)
      XREQ_ON:    ext_hit = ext_q;
      XREQ_GATED: ext_hit = ext_q && lat_exp_o;
      default:    ext_hit = 1'b0;
    endcase
  end

  assign rel_o = lat_exp_o || ext_hit || slave_pend_i;

endmodule

// File: rtl/dma_lbus_owner.sv
module dma_lbus_owner
  import dma_lbus_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  input  logic             ext_req_i,
  input  logic [1:0]       ext_mode_i,
  input  logic             slave_pend_i,
  input  logic             eot_i,
  input  logic             eot_en_i,
  input  logic [TMR_W-1:0] lat_val_i,
  input  logic [TMR_W-1:0] pause_val_i,
  input  logic             hold_ack_i,
  output logic             hold_o,
  output logic             drive_en_o,
  output logic             xfer_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LW_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LW_ZERO = '0;

  own_st_e          st;
  logic [CNT_W-1:0] lw_left;
  logic             dir_q;
  logic [TMR_W-1:0] lat_cnt;
  logic [TMR_W-1:0] pause_cnt;
  logic             lat_exp;
  logic             rel_any;
  logic             owned;
  logic             blocked;
  logic             eot_hit;
  logic             last_lw;
  logic             finish;
  logic             go_pause;

  // Bus ownership and strobe
  assign owned      = (st == ST_OWN) && hold_ack_i;
  assign blocked    = dir_q ? fifo_full_i : fifo_empty_i;
  assign eot_hit    = eot_en_i && eot_i;
  assign drive_en_o = owned;
  assign xfer_o     = owned && !blocked;
  assign hold_o     = (st == ST_REQ) || (st == ST_OWN);

  // Completion takes priority over every release reason
  assign last_lw  = xfer_o && (lw_left == LW_ONE);
  assign finish   = owned && (last_lw || eot_hit);
  assign go_pause = owned && !finish && (blocked || rel_any);

  dma_lbus_tmr #(.W(TMR_W)) i_lat_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i ((st == ST_REQ) && hold_ack_i),
    .val_i  (lat_val_i),
    .run_i  (st == ST_OWN),
    .cnt_o  (lat_cnt)
  );

  dma_lbus_tmr #(.W(TMR_W)) i_pause_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (go_pause),
    .val_i  (pause_val_i),
    .run_i  (st == ST_PAUSE),
    .cnt_o  (pause_cnt)
  );

  dma_lbus_rel #(.TMR_W(TMR_W)) i_rel (
    .clk          (clk),
    .rst          (rst),
    .ext_req_i    (ext_req_i),
    .ext_mode_i   (ext_mode_i),
    .slave_pend_i (slave_pend_i),
    .lat_val_i    (lat_val_i),
    .lat_cnt_i    (lat_cnt),
    .lat_exp_o    (lat_exp),
    .rel_o        (rel_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      lw_left <= LW_ZERO;
      dir_q   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (count_i == LW_ZERO) begin
              done_o <= 1'b1;
            end else begin
              lw_left <= count_i;
              dir_q   <= dir_i;
              st      <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (hold_ack_i) st <= ST_OWN;
        end
        ST_OWN: begin
          if (xfer_o) lw_left <= lw_left - LW_ONE;
          if (finish) begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
          end else if (go_pause) begin
            st <= ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          if (pause_cnt == '0 && !hold_ack_i) st <= ST_REQ;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_lbus_owner_chk.sv
module dma_lbus_owner_chk #(
  parameter int CNT_W = 16,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             fifo_full_i,
  input logic             fifo_empty_i,
  input logic             slave_pend_i,
  input logic             eot_i,
  input logic             eot_en_i,
  input logic [TMR_W-1:0] lat_val_i,
  input logic             hold_ack_i,
  input logic             hold_o,
  input logic             drive_en_o,
  input logic             xfer_o,
  input logic             done_o,
  input logic             dir_q,
  input logic [CNT_W-1:0] lw_left
);

  logic [TMR_W:0] own_run;
  logic           blk;

  assign blk = dir_q ? fifo_full_i : fifo_empty_i;

  always_ff @(posedge clk) begin
    if (rst || !hold_o)           own_run <= '0;
    else if (drive_en_o && own_run != '1) own_run <= own_run + 1'b1;
  end

  // R2: bus driven only while owned
  assert_drive_owned_R2: assert property (@(posedge clk) disable iff (rst)
    drive_en_o |-> (hold_o && hold_ack_i));

  // R3: no strobe while FIFO blocks; blocked owned cycle releases
  assert_no_blocked_xfer_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_o |-> !blk);
  assert_block_release_R3: assert property (@(posedge clk) disable iff (rst)
    (drive_en_o && blk && !(eot_en_i && eot_i)) |=> !hold_o);

  // R4: final longword completes the job with a single done pulse
  assert_last_done_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_o && lw_left == CNT_W'(1)) |=> done_o);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !hold_o);

  // R5: tenure no longer than the latency value
  assert_tenure_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_o && lat_val_i != '0) |-> (own_run < {1'b0, lat_val_i}));

  // R6: re-request only after acknowledge was seen low
  assert_rerequest_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_o && !$past(hold_o) && !$past(start_i)) |-> !$past(hold_ack_i));

  // R8: pending slave access releases the bus
  assert_slave_release_R8: assert property (@(posedge clk) disable iff (rst)
    (drive_en_o && slave_pend_i) |=> !hold_o);

  // R9: enabled end-of-transfer ends the job
  assert_eot_done_R9: assert property (@(posedge clk) disable iff (rst)
    (drive_en_o && eot_en_i && eot_i) |=> done_o);

endmodule

bind dma_lbus_owner dma_lbus_owner_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_empty_i (fifo_empty_i),
  .slave_pend_i (slave_pend_i),
  .eot_i        (eot_i),
  .eot_en_i     (eot_en_i),
  .lat_val_i    (lat_val_i),
  .hold_ack_i   (hold_ack_i),
  .hold_o       (hold_o),
  .drive_en_o   (drive_en_o),
  .xfer_o       (xfer_o),
  .done_o       (done_o),
  .dir_q        (dir_q),
  .lw_left      (lw_left)
);

// File: tb/test_dma_lbus_owner.sv
module test_dma_lbus_owner;

  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int TMR_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             dir_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             fifo_full_i = 1'b0;
  logic             fifo_empty_i = 1'b0;
  logic             ext_req_i = 1'b0;
  logic [1:0]       ext_mode_i = 2'd0;
  logic             slave_pend_i = 1'b0;
  logic             eot_i = 1'b0;
  logic             eot_en_i = 1'b0;
  logic [TMR_W-1:0] lat_val_i = '0;
  logic [TMR_W-1:0] pause_val_i = '0;
  logic             hold_ack_i;
  logic             hold_o, drive_en_o, xfer_o, done_o;
  logic             grant_en = 1'b1;
  logic             other_busy = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int w_strobes, w_rels, w_max_ten, w_min_gap, w_post, w_bad, w_hold_after, w_timeout;

  always #(CLK_P/2) clk = ~clk;

  // Arbiter model: grant follows hold, or the bus is held by another master
  assign hold_ack_i = (hold_o && grant_en) || other_busy;

  dma_lbus_owner #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_dma_lbus_owner (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i), .count_i(count_i),
    .fifo_full_i(fifo_full_i), .fifo_empty_i(fifo_empty_i),
    .ext_req_i(ext_req_i), .ext_mode_i(ext_mode_i), .slave_pend_i(slave_pend_i),
    .eot_i(eot_i), .eot_en_i(eot_en_i), .lat_val_i(lat_val_i),
    .pause_val_i(pause_val_i), .hold_ack_i(hold_ack_i),
    .hold_o(hold_o), .drive_en_o(drive_en_o), .xfer_o(xfer_o), .done_o(done_o)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_le(input string req, input int act, input int lim);
    checks++;
    if (act > lim) begin
      errors++;
      $display("FAIL %s actual %0d expected at most %0d", req, act, lim);
    end
  endtask

  task automatic start_job(input logic dir, input int n);
    @(negedge clk);
    dir_i   = dir;
    count_i = CNT_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // kind: 0 none, 1 ext_req, 2 slave_pend, 3 eot, 4 start while busy, 5 other master after release
  task automatic watch(input int kind, input int trig_at);
    bit prev_hold, fired, live, in_gap, post_on;
    int ten, gap, busy_left;
    w_strobes = 0; w_rels = 0; w_max_ten = 0; w_min_gap = 9999;
    w_post = 0; w_bad = 0; w_hold_after = 0; w_timeout = 1;
    prev_hold = hold_o; fired = 0; live = 0; in_gap = 0; post_on = 0;
    ten = 0; gap = 0; busy_left = 0;
    for (int c = 0; c < 3000; c++) begin
      if (live) begin
        ext_req_i = 0; slave_pend_i = 0; eot_i = 0; start_i = 0; live = 0;
      end
      if (other_busy) begin
        if (hold_o) w_bad++;
        busy_left--;
        if (busy_left == 0) other_busy = 1'b0;
      end
      if (xfer_o) begin
        w_strobes++; ten++;
        if (ten > w_max_ten) w_max_ten = ten;
        if (post_on) w_post++;
      end
      if (prev_hold && !hold_o && !done_o) begin
        w_rels++; in_gap = 1; gap = 1; post_on = 0;
        if (kind == 5 && !fired) begin
          fired = 1; other_busy = 1'b1; busy_left = 8;
        end
      end else if (!hold_o && in_gap) begin
        gap++;
      end else if (hold_o && !prev_hold) begin
        if (in_gap && gap < w_min_gap) w_min_gap = gap;
        in_gap = 0; ten = 0;
      end
      prev_hold = hold_o;
      if (done_o) begin
        w_timeout = 0;
        break;
      end
      if (!fired && kind >= 1 && kind <= 4 && w_strobes == trig_at) begin
        fired = 1; live = 1; post_on = 1;
        case (kind)
          1: ext_req_i = 1'b1;
          2: slave_pend_i = 1'b1;
          3: eot_i = 1'b1;
          default: begin count_i = CNT_W'(100); start_i = 1'b1; end
        endcase
      end
      @(negedge clk);
    end
    ext_req_i = 0; slave_pend_i = 0; eot_i = 0; start_i = 0; other_busy = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (hold_o || done_o) w_hold_after = 1;
    end
    chk_eq("watch completion", w_timeout, 0);
  endtask

  task automatic set_cfg(input int lat, input int pau, input int mode, input bit eoten);
    lat_val_i = TMR_W'(lat); pause_val_i = TMR_W'(pau);
    ext_mode_i = 2'(mode); eot_en_i = eoten;
  endtask

  task automatic test_reset;
    chk_eq("R1 hold", int'(hold_o), 0);
    chk_eq("R1 drive", int'(drive_en_o), 0);
    chk_eq("R1 xfer", int'(xfer_o), 0);
    chk_eq("R1 done", int'(done_o), 0);
  endtask

  task automatic test_handshake;
    set_cfg(0, 0, 0, 0);
    start_job(1'b0, 2);
    chk_eq("R2 hold after start", int'(hold_o), 1);
    chk_eq("R2 no drive in request", int'(drive_en_o), 0);
    @(negedge clk);
    chk_eq("R2 drive after ack", int'(drive_en_o), 1);
    chk_eq("R3 first strobe", int'(xfer_o), 1);
    @(negedge clk);
    chk_eq("R3 second strobe", int'(xfer_o), 1);
    @(negedge clk);
    chk_eq("R4 done after last", int'(done_o), 1);
    chk_eq("R4 hold dropped", int'(hold_o), 0);
    @(negedge clk);
    chk_eq("R4 done one cycle", int'(done_o), 0);
  endtask

  task automatic test_zero_count;
    start_job(1'b1, 0);
    chk_eq("R4 zero count done", int'(done_o), 1);
    chk_eq("R4 zero count no hold", int'(hold_o), 0);
  endtask

  task automatic test_latency;
    set_cfg(3, 2, 0, 0);
    start_job(1'b1, 8); watch(0, 0);
    chk_eq("R5 strobes", w_strobes, 8);
    chk_eq("R5 releases", w_rels, 2);
    chk_eq("R5 longest tenure", w_max_ten, 3);
    chk_eq("R6 pause gap P+1", w_min_gap, 3);
    set_cfg(0, 2, 0, 0);
    start_job(1'b1, 12); watch(0, 0);
    chk_eq("R5 timer off no release", w_rels, 0);
    chk_eq("R5 timer off strobes", w_strobes, 12);
  endtask

  task automatic test_final_coincide;
    set_cfg(4, 0, 0, 0);
    start_job(1'b0, 8); watch(0, 0);
    chk_eq("R10 strobes", w_strobes, 8);
    chk_eq("R10 single release", w_rels, 1);
    chk_eq("R10 idle after done", w_hold_after, 0);
  endtask

  task automatic test_other_master;
    set_cfg(2, 0, 0, 0);
    start_job(1'b0, 6); watch(5, 0);
    chk_eq("R6 no request while ack high", w_bad, 0);
    chk_eq("R6 resumes full count", w_strobes, 6);
    chk_eq("R6 releases", w_rels, 2);
  endtask

  task automatic test_ext;
    set_cfg(0, 1, 1, 0);
    start_job(1'b0, 20); watch(1, 3);
    chk_eq("R7 enabled releases", w_rels, 1);
    chk_le("R7 strobes after request", w_post, 2);
    chk_eq("R7 enabled total", w_strobes, 20);
    set_cfg(0, 1, 0, 0);
    start_job(1'b0, 20); watch(1, 3);
    chk_eq("R7 disabled ignored", w_rels, 0);
    set_cfg(0, 1, 2, 0);
    start_job(1'b0, 20); watch(1, 3);
    chk_eq("R7 gated without timer ignored", w_rels, 0);
    chk_eq("R7 gated total", w_strobes, 20);
  endtask

  task automatic test_slave;
    set_cfg(0, 1, 0, 0);
    start_job(1'b1, 10); watch(2, 2);
    chk_eq("R8 slave release", w_rels, 1);
    chk_eq("R8 no further strobe", w_post, 0);
    chk_eq("R8 total", w_strobes, 10);
  endtask

  task automatic test_eot;
    set_cfg(0, 0, 0, 1);
    start_job(1'b0, 10); watch(3, 3);
    chk_eq("R9 early end strobes", w_strobes, 3);
    set_cfg(0, 0, 0, 0);
    start_job(1'b0, 10); watch(3, 3);
    chk_eq("R9 disabled ignored", w_strobes, 10);
  endtask

  task automatic test_busy_start;
    set_cfg(0, 0, 0, 0);
    start_job(1'b1, 7); watch(4, 2);
    chk_eq("R11 count unchanged", w_strobes, 7);
    chk_eq("R11 no new job", w_hold_after, 0);
  endtask

  task automatic test_block;
    int s, f;
    bit ph;
    set_cfg(0, 1, 0, 0);
    fifo_full_i = 1'b1;
    start_job(1'b1, 4);
    s = 0; f = 0; ph = hold_o;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (xfer_o) s++;
      if (ph && !hold_o) f++;
      ph = hold_o;
    end
    chk_eq("R3 full blocks local-to-host", s, 0);
    chk_eq("R3 blocked releases", int'(f > 0), 1);
    fifo_full_i = 1'b0;
    watch(0, 0);
    chk_eq("R3 resumes after full clears", w_strobes, 4);
    fifo_empty_i = 1'b1;
    start_job(1'b1, 4); watch(0, 0);
    chk_eq("R3 empty ignored local-to-host", w_strobes, 4);
    chk_eq("R3 empty no release local-to-host", w_rels, 0);
    fifo_empty_i = 1'b0;
    fifo_full_i = 1'b1;
    start_job(1'b0, 4); watch(0, 0);
    chk_eq("R3 full ignored host-to-local", w_rels, 0);
    fifo_full_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset;
    test_handshake;
    test_zero_count;
    test_latency;
    test_final_coincide;
    test_other_master;
    test_ext;
    test_slave;
    test_eot;
    test_busy_start;
    test_block;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule